// File: doc/BRIEF.md
# Floating-Point Exception Arbiter with Default Results

This unit sits at the back end of a single-precision floating-point pipeline. For each completed operation it takes the condition indicators from the arithmetic stage, the computed word with the sign of its unrounded value, and the control fields (per-condition enables, the denormal flush control and the rounding mode). It then decides whether the operation traps or writes back. One cycle after an operation is presented, the unit raises a single trap request or asserts a destination write enable together with the final 32-bit word.

Different conditions trap on different grounds. Overflow, underflow and inexactness trap when they are merely possible and their enable is set. A denormal operand traps whenever flushing is off, whatever the enables are. An operation that does not trap writes a substitute value chosen by a fixed priority and sets the sticky flags of the conditions it raised. A per-operation cause field records what the last operation raised. Software reads the cause and flags to tell the trap sources apart. It clears or loads the flags through a write port.

Top module: `fpu_exc_unit`

## Requirements
- R1: After reset, trapReq, dstWe, causeOut, flagOut and resOut are all zero.
- R2: A denormal operand (condDenorm) with flushDn=0 makes trapReq=1 and dstWe=0 in the cycle after opValid, for any enable setting. With flushDn=1 the denormal indicator has no effect.
- R3: The invalid trap fires when enMask[4] (V) is 1 and either condInvalid or isVecXform is 1. isVecXform with enMask[4]=0 has no effect.
- R4: The divide-by-zero trap fires when enMask[3] (Z) is 1 and either condZeroDiv or condRsqrtZero is 1.
- R5: The overflow, underflow and inexact traps fire when enMask[2] (O), enMask[1] (U) or enMask[0] (I) is 1 and the matching possibility indicator (condOvf, condUnf, condInex) is 1.
- R6: All trap sources drive the one trapReq output. A trapping operation gives dstWe=0 and leaves flagOut unchanged. An operation that does not trap gives dstWe=1 and trapReq=0. Both outputs last one cycle.
- R7: An operation that does not trap ORs its conditions into flagOut: bit 4 is condInvalid, bit 3 is condZeroDiv|condRsqrtZero, bit 2 is condOvf, bit 1 is condUnf and bit 0 is condInex. The flags stay set until written.
- R8: A written result with condInvalid is the quiet NaN 0x7FC00000. Invalid has priority over every other default.
- R9: With no invalid condition, a divide-by-zero result is infinity {resSign, 0xFF exponent, zero fraction}.
- R10: With neither invalid nor divide-by-zero, an overflow result is {resSign, 0x7F7FFFFF} when rndMode=1 (toward zero). It is {resSign, 0x7F800000} when rndMode=0 (nearest).
- R11: With only underflow among V/Z/O, the result is {resSign, 31 zero bits} when flushDn=1 and resIn when flushDn=0. With none of V/Z/O/U, the result is resIn.
- R12: Each operation replaces causeOut with {bit5 denormal trap, bit4 condInvalid or invalid trap, bit3 divide-by-zero, bit2 condOvf, bit1 condUnf, bit0 condInex}. Without opValid, causeOut holds and dstWe and trapReq are 0.
- R13: flagWrEn=1 loads flagOut with flagWrData in the next cycle. This overrides any accumulation from an operation in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | An operation completes this cycle |
| condDenorm | input | 1 | A denormal operand was seen |
| condInvalid | input | 1 | Invalid operation |
| condZeroDiv | input | 1 | Division with zero divisor |
| condRsqrtZero | input | 1 | Reciprocal square root of zero |
| condOvf | input | 1 | Overflow possible |
| condUnf | input | 1 | Underflow possible |
| condInex | input | 1 | Inexact result possible |
| isVecXform | input | 1 | Opcode belongs to the vector-transform class |
| resIn | input | 32 | Computed result word |
| resSign | input | 1 | Sign of the unrounded value |
| enMask | input | 5 | Trap enables {V,Z,O,U,I} |
| flushDn | input | 1 | Denormal flush control |
| rndMode | input | 1 | 0 nearest, 1 toward zero |
| flagWrEn | input | 1 | Load sticky flags |
| flagWrData | input | 5 | Value loaded into flags |
| trapReq | output | 1 | Single exception request |
| dstWe | output | 1 | Destination write enable |
| resOut | output | 32 | Final result word |
| causeOut | output | 6 | Causes of the last operation |
| flagOut | output | 5 | Sticky flags {V,Z,O,U,I} |

## Verification
The bench sweeps every combination of the eight condition indicators, the five enables, the flush control and the rounding mode. It compares the outputs with an arithmetic model. The sweep covers several cases an incorrect design gets wrong. A design that gated the denormal trap by an enable would write back a denormal operation instead of trapping. One that let divide-by-zero outrank invalid would write infinity where the quiet NaN belongs. One that mixed up the rounding modes would return infinity where the largest finite value is expected. The bench also checks that a trapping operation leaves the flags untouched and that a flag write overrides a same-cycle accumulation. A design that got either wrong would show the wrong flags.

// File: rtl/fexc_pkg.sv
package fexc_pkg;
  parameter int EXP_W = 8;
  parameter int MAN_W = 23;
  localparam int WORD_W = 1 + EXP_W + MAN_W;
  localparam int NUM_FLAG = 5;
  localparam int NUM_CAUSE = NUM_FLAG + 1;
  localparam int FV = 4;
  localparam int FZ = 3;
  localparam int FO = 2;
  localparam int FU = 1;
  localparam int FI = 0;
  localparam int CE = NUM_FLAG;

  typedef enum logic [2:0] {
    SEL_PASS,
    SEL_QNAN,
    SEL_INF,
    SEL_MAXF,
    SEL_ZERO
  } resSel_e;

  typedef struct packed {
    logic                 capture;
    logic                 trap;
    logic                 write;
    resSel_e              sel;
    logic [NUM_FLAG-1:0]  setFlag;
    logic [NUM_CAUSE-1:0] cause;
  } strobe_t;
endpackage

// File: rtl/fexc_ctrl.sv
module fexc_ctrl
  import fexc_pkg::*;
(
  input  logic                opValid,
  input  logic                condDenorm,
  input  logic                condInvalid,
  input  logic                condZeroDiv,
  input  logic                condRsqrtZero,
  input  logic                condOvf,
  input  logic                condUnf,
  input  logic                condInex,
  input  logic                isVecXform,
  input  logic [NUM_FLAG-1:0] enMask,
  input  logic                flushDn,
  output strobe_t             strobe
);
  logic divZero;
  logic trapE, trapV, trapZ, trapO, trapU, trapI;
  logic anyTrap;
  logic [NUM_FLAG-1:0] raised;

  always_comb begin
    divZero = condZeroDiv | condRsqrtZero;
    trapE   = condDenorm & ~flushDn;
    trapV   = enMask[FV] & (condInvalid | isVecXform);
    trapZ   = enMask[FZ] & divZero;
    trapO   = enMask[FO] & condOvf;
    trapU   = enMask[FU] & condUnf;
    trapI   = enMask[FI] & condInex;
    anyTrap = trapE | trapV | trapZ | trapO | trapU | trapI;

    raised      = '0;
    raised[FV]  = condInvalid;
    raised[FZ]  = divZero;
    raised[FO]  = condOvf;
    raised[FU]  = condUnf;
    raised[FI]  = condInex;

    strobe.capture = opValid;
    strobe.trap    = opValid & anyTrap;
    strobe.write   = opValid & ~anyTrap;
    strobe.setFlag = (opValid & ~anyTrap) ? raised : '0;

    strobe.cause     = '0;
    strobe.cause[CE] = trapE;
    strobe.cause[FV] = condInvalid | trapV;
    strobe.cause[FZ] = divZero;
    strobe.cause[FO] = condOvf;
    strobe.cause[FU] = condUnf;
    strobe.cause[FI] = condInex;

    if (condInvalid)            strobe.sel = SEL_QNAN;
    else if (divZero)           strobe.sel = SEL_INF;
    else if (condOvf)           strobe.sel = SEL_MAXF;
    else if (condUnf & flushDn) strobe.sel = SEL_ZERO;
    else                        strobe.sel = SEL_PASS;
  end
endmodule

// File: rtl/fexc_dpath.sv
module fexc_dpath
  import fexc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobe,
  input  logic [WORD_W-1:0]    resIn,
  input  logic                 resSign,
  input  logic                 rndMode,
  input  logic                 flagWrEn,
  input  logic [NUM_FLAG-1:0]  flagWrData,
  output logic                 trapReq,
  output logic                 dstWe,
  output logic [WORD_W-1:0]    resOut,
  output logic [NUM_CAUSE-1:0] causeOut,
  output logic [NUM_FLAG-1:0]  flagOut
);
  localparam logic [EXP_W-1:0] EXP_ONES = {EXP_W{1'b1}};

  logic [WORD_W-1:0] qNan, infVal, maxFin, sZero, ovfVal, nextRes;

  always_comb begin
    qNan   = {1'b0, EXP_ONES, 1'b1, {(MAN_W-1){1'b0}}};
    infVal = {resSign, EXP_ONES, {MAN_W{1'b0}}};
    maxFin = {resSign, EXP_ONES - 1'b1, {MAN_W{1'b1}}};
    sZero  = {resSign, {(WORD_W-1){1'b0}}};
    ovfVal = rndMode ? maxFin : infVal;
    case (strobe.sel)
      SEL_QNAN: nextRes = qNan;
      SEL_INF:  nextRes = infVal;
      SEL_MAXF: nextRes = ovfVal;
      SEL_ZERO: nextRes = sZero;
      default:  nextRes = resIn;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trapReq  <= 1'b0;
      dstWe    <= 1'b0;
      resOut   <= '0;
      causeOut <= '0;
    end else begin
      trapReq <= strobe.trap;
      dstWe   <= strobe.write;
      if (strobe.write) resOut <= nextRes;
      if (strobe.capture) causeOut <= strobe.cause;
    end
  end

  for (genvar b = 0; b < NUM_FLAG; b++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         flagOut[b] <= 1'b0;
      else if (flagWrEn) flagOut[b] <= flagWrData[b];
      else if (strobe.setFlag[b]) flagOut[b] <= 1'b1;
    end
  end

  assert_trap_no_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    trapReq |-> !dstWe);
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    !flagWrEn |=> ((flagOut & $past(flagOut)) == $past(flagOut)));
  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capture |=> (!dstWe && !trapReq && $stable(causeOut)));
  assert_flag_load_R13: assert property (@(posedge clk) disable iff (!rstN)
    flagWrEn |=> (flagOut == $past(flagWrData)));
endmodule

// File: rtl/fpu_exc_unit.sv
module fpu_exc_unit
  import fexc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 opValid,
  input  logic                 condDenorm,
  input  logic                 condInvalid,
  input  logic                 condZeroDiv,
  input  logic                 condRsqrtZero,
  input  logic                 condOvf,
  input  logic                 condUnf,
  input  logic                 condInex,
  input  logic                 isVecXform,
  input  logic [WORD_W-1:0]    resIn,
  input  logic                 resSign,
  input  logic [NUM_FLAG-1:0]  enMask,
  input  logic                 flushDn,
  input  logic                 rndMode,
  input  logic                 flagWrEn,
  input  logic [NUM_FLAG-1:0]  flagWrData,
  output logic                 trapReq,
  output logic                 dstWe,
  output logic [WORD_W-1:0]    resOut,
  output logic [NUM_CAUSE-1:0] causeOut,
  output logic [NUM_FLAG-1:0]  flagOut
);
  strobe_t strobe;

  fexc_ctrl i_ctrl (
    .opValid(opValid), .condDenorm(condDenorm), .condInvalid(condInvalid),
    .condZeroDiv(condZeroDiv), .condRsqrtZero(condRsqrtZero),
    .condOvf(condOvf), .condUnf(condUnf), .condInex(condInex),
    .isVecXform(isVecXform), .enMask(enMask), .flushDn(flushDn),
    .strobe(strobe)
  );

  fexc_dpath i_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .resIn(resIn),
    .resSign(resSign), .rndMode(rndMode), .flagWrEn(flagWrEn),
    .flagWrData(flagWrData), .trapReq(trapReq), .dstWe(dstWe),
    .resOut(resOut), .causeOut(causeOut), .flagOut(flagOut)
  );

  assert_denorm_trap_R2: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && condDenorm && !flushDn) |=> (trapReq && !dstWe));
  assert_vec_trap_R3: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && isVecXform && enMask[FV]) |=> trapReq);
  assert_qnan_R8: assert property (@(posedge clk) disable iff (!rstN)
    (opValid && condInvalid) |=> (!dstWe || resOut == {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}}));
endmodule

// File: tb/test_fpu_exc_unit.sv
`timescale 1ns/1ps
module test_fpu_exc_unit;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic opValid = 0, condDenorm = 0, condInvalid = 0, condZeroDiv = 0;
  logic condRsqrtZero = 0, condOvf = 0, condUnf = 0, condInex = 0, isVecXform = 0;
  logic [31:0] resIn = '0;
  logic resSign = 0;
  logic [4:0] enMask = '0;
  logic flushDn = 0, rndMode = 0, flagWrEn = 0;
  logic [4:0] flagWrData = '0;
  logic trapReq, dstWe;
  logic [31:0] resOut;
  logic [5:0] causeOut;
  logic [4:0] flagOut;

  int nChecks = 0;
  int nFail = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  fpu_exc_unit i_fpu_exc_unit (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      nFail++; nChecks++;
      $display("FAIL watchdog actual=%0d expected<190000", cycles);
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    logic [31:0] expRes;
    logic [5:0]  expCause;
    logic [4:0]  expFlag, wp, raised;
    logic divz, trap;
    logic [31:0] prevRes;
    repeat (3) @(negedge clk);
    check("R1 trapReq", {31'b0, trapReq}, 0);
    check("R1 dstWe", {31'b0, dstWe}, 0);
    check("R1 cause", {26'b0, causeOut}, 0);
    check("R1 flags", {27'b0, flagOut}, 0);
    check("R1 result", resOut, 0);
    rstN = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 32768; i++) begin
      logic [14:0] v;
      v = i[14:0];
      wp = 5'(i * 7);
      flagWrEn = 1'b1; flagWrData = wp;
      @(negedge clk);
      flagWrEn = 1'b0;
      {condDenorm, condInvalid, condZeroDiv, condRsqrtZero, condOvf, condUnf, condInex, isVecXform} = v[7:0];
      enMask = v[12:8]; flushDn = v[13]; rndMode = v[14];
      resSign = i[3] ^ i[9];
      resIn = 32'h0012_3456 ^ (i * 32'h0001_0F31);
      opValid = 1'b1;
      divz = condZeroDiv | condRsqrtZero;
      trap = (condDenorm & ~flushDn) | (enMask[4] & (condInvalid | isVecXform)) |
             (enMask[3] & divz) | (enMask[2] & condOvf) | (enMask[1] & condUnf) |
             (enMask[0] & condInex);
      raised = {condInvalid, divz, condOvf, condUnf, condInex};
      expFlag = trap ? wp : (wp | raised);
      expCause = {condDenorm & ~flushDn, condInvalid | (enMask[4] & (condInvalid | isVecXform)),
                  divz, condOvf, condUnf, condInex};
      if (condInvalid) expRes = 32'h7FC0_0000;
      else if (divz) expRes = {resSign, 31'h7F80_0000};
      else if (condOvf) expRes = rndMode ? {resSign, 31'h7F7F_FFFF} : {resSign, 31'h7F80_0000};
      else if (condUnf && flushDn) expRes = {resSign, 31'h0};
      else expRes = resIn;
      @(negedge clk);
      opValid = 1'b0;
      check("R2 R3 R4 R5 R6 trapReq", {31'b0, trapReq}, {31'b0, trap});
      check("R6 dstWe", {31'b0, dstWe}, {31'b0, ~trap});
      check("R7 R6 flags", {27'b0, flagOut}, {27'b0, expFlag});
      check("R12 cause", {26'b0, causeOut}, {26'b0, expCause});
      if (!trap) check("R8 R9 R10 R11 result", resOut, expRes);
      if (i % 1024 == 5) begin
        prevRes = resOut;
        @(negedge clk);
        check("R12 idle dstWe", {31'b0, dstWe}, 0);
        check("R12 idle trapReq", {31'b0, trapReq}, 0);
        check("R12 cause held", {26'b0, causeOut}, {26'b0, expCause});
        check("R12 result held", resOut, prevRes);
      end
    end

    flagWrEn = 1'b1; flagWrData = 5'b00000;
    @(negedge clk);
    flagWrData = 5'b00010;
    opValid = 1'b1; enMask = 5'b0; flushDn = 1'b1;
    {condDenorm, condInvalid, condZeroDiv, condRsqrtZero, condOvf, condUnf, condInex, isVecXform} = 8'b0100_0010;
    @(negedge clk);
    flagWrEn = 1'b0; opValid = 1'b0;
    check("R13 write overrides accumulation", {27'b0, flagOut}, 32'h2);
    check("R8 qNaN written", resOut, 32'h7FC0_0000);
    @(negedge clk);
    check("R13 flags kept", {27'b0, flagOut}, 32'h2);

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule